// File: doc/BRIEF.md
# SDRAM Read Burst Column Sequencer

This block reproduces the order in which a synchronous DRAM walks through column addresses during a read burst. The controller or a reference model samples the mode settings on a start strobe. These are the burst length code, the wrap order and the CAS latency, sampled together with a 9-bit starting column. From the next clock on, the block issues one column address per cycle. A data-valid flag follows the issued addresses after the CAS latency, so a read-tracking path knows in which cycle each returned word lands. A done flag marks the final word of a fixed-length burst.

A terminate input stops address issue at once. Words already in the latency pipeline still come out. A new start strobe in the middle of a burst abandons the old one and begins the new sequence at once. Full-page bursts sweep all 512 columns with wraparound and run until they are stopped.

Top module: `sdr_burst_seq`

## Requirements
- R1: The length code gives the burst length: code 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, and any code with bit 2 set gives a full page. A fixed burst started at sampling edge e issues exactly its length of addresses (col_valid_o high) after edges e through e+L-1, then col_valid_o falls.
- R2: With burst_type_i = 0 (sequential), the k-th address is the start column with its low log2(L) bits replaced by (start + k) mod L. The upper bits stay equal to those of the start column.
- R3: With burst_type_i = 1 (interleaved), the k-th address is the start column XOR k, where k runs from 0 to L-1 and touches only the low log2(L) bits.
- R4: A full-page burst ignores burst_type_i and issues start+k mod 512, wrapping from 511 to 0. It continues until a terminate or a new start, and it never raises burst_done_o.
- R5: cas_lat_i = 0 selects latency 2 and 1 selects latency 3. data_valid_o after edge n equals col_valid_o after edge n-CL, so the first word is flagged CL edges after the start is sampled.
- R6: burst_done_o is high for exactly one cycle, together with the data_valid_o of the last word of a fixed-length burst.
- R7: term_i sampled without start_i stops address issue from that edge onward. Words already issued still produce their data_valid_o. If start_i and term_i are sampled together, the start wins.
- R8: A start_i sampled during a burst ends the old burst and issues the new starting column at that same edge. The old burst gives no burst_done_o.
- R9: While rst_ni is low, every output is 0.
- R10: The column, length, order and latency inputs are sampled only on a start. Changing them during a burst does not alter the addresses or flags of that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for a new burst |
| start_col_i | input | 9 | Starting column |
| burst_len_i | input | 3 | Burst length code |
| burst_type_i | input | 1 | 0 sequential, 1 interleaved |
| cas_lat_i | input | 1 | 0 latency 2, 1 latency 3 |
| term_i | input | 1 | Burst terminate |
| col_o | output | 9 | Column address issued this cycle |
| col_valid_o | output | 1 | col_o holds an issued address |
| data_valid_o | output | 1 | Data word for an earlier address is valid |
| burst_done_o | output | 1 | Last data word of a fixed-length burst |

## Verification
Directed bursts run every length code from an unaligned start column, in both orders. This separates sequential wrap inside the aligned block from the interleaved XOR pattern, and an off-by-one in the block mask from a wrong order. A full-page run started near the top of the page shows the 511-to-0 wrap and the missing done pulse. Bursts at each latency, termination mid-burst, a simultaneous start and terminate, and a restart mid-burst tell a wrong delay tap apart from a pipeline that fails to drain or a flag left over from an abandoned burst. A long constrained-random run changes the mode inputs every cycle between strobes, which exposes any path that reads them outside a start.

// File: rtl/sdr_burst_pkg.sv
package sdr_burst_pkg;
  localparam int COL_W_DEF  = 9;
  localparam int LEN_W      = 3;
  localparam int MAX_CL_DEF = 3;

  typedef enum logic {
    ORD_SEQ   = 1'b0,
    ORD_INTLV = 1'b1
  } burst_order_e;
endpackage

// File: rtl/sdr_col_gen.sv
module sdr_col_gen
  import sdr_burst_pkg::*;
#(
  parameter int COL_W = COL_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             term_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [LEN_W-1:0] len_code_i,
  input  burst_order_e     order_i,
  output logic [COL_W-1:0] col_o,
  output logic             col_vld_o,
  output logic             last_o
);
  logic [COL_W-1:0] base_q, cnt_q, col_q, mask_w, addr_w;
  logic [LEN_W-1:0] code_q;
  burst_order_e     order_q;
  logic             busy_q, vld_q, last_q, full_w, is_last_w, len1_w;

  assign full_w    = code_q[LEN_W-1];
  assign mask_w    = full_w ? '1 : COL_W'((1 << code_q[1:0]) - 1);
  assign is_last_w = !full_w && (cnt_q == mask_w);
  assign len1_w    = (len_code_i == '0);

  always_comb begin
    if (full_w)
      addr_w = base_q + cnt_q;
    else if (order_q == ORD_INTLV)
      addr_w = base_q ^ (cnt_q & mask_w);
    else
      addr_w = (base_q & ~mask_w) | ((base_q + cnt_q) & mask_w);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      code_q  <= '0;
      order_q <= ORD_SEQ;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      col_q   <= '0;
      vld_q   <= 1'b0;
      last_q  <= 1'b0;
    end else if (start_i) begin
      base_q  <= start_col_i;
      code_q  <= len_code_i;
      order_q <= order_i;
      cnt_q   <= COL_W'(1);
      busy_q  <= !len1_w;
      col_q   <= start_col_i;
      vld_q   <= 1'b1;
      last_q  <= len1_w;
    end else if (term_i || !busy_q) begin
      busy_q <= 1'b0;
      vld_q  <= 1'b0;
      last_q <= 1'b0;
    end else begin
      col_q  <= addr_w;
      vld_q  <= 1'b1;
      last_q <= is_last_w;
      busy_q <= !is_last_w;
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign col_o     = col_q;
  assign col_vld_o = vld_q;
  assign last_o    = last_q;

  p_start_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (col_vld_o && col_o == $past(start_col_i)));

  p_term_halt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_i && !start_i) |=> !col_vld_o);

  p_block_fixed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && !full_w) |-> (((col_q ^ base_q) & ~mask_w) == '0));

  p_page_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && $past(vld_q) && full_w && !$past(start_i)) |-> (col_q == $past(col_q) + 1'b1));
endmodule

// File: rtl/sdr_lat_pipe.sv
module sdr_lat_pipe
  import sdr_burst_pkg::*;
#(
  parameter int MAX_CL = MAX_CL_DEF,
  localparam int TAP_W = (MAX_CL > 1) ? $clog2(MAX_CL) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic             last_i,
  input  logic [TAP_W-1:0] tap_i,
  output logic             dv_o,
  output logic             done_o
);
  logic [MAX_CL-1:0] vld_sr, last_sr;

  // stage k holds the flag delayed by k+1 edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_sr  <= '0;
      last_sr <= '0;
    end else begin
      vld_sr  <= {vld_sr[MAX_CL-2:0], vld_i};
      last_sr <= {last_sr[MAX_CL-2:0], last_i};
    end
  end

  assign dv_o   = vld_sr[tap_i];
  assign done_o = last_sr[tap_i];

  p_done_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> dv_o);
endmodule

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq
  import sdr_burst_pkg::*;
#(
  parameter int COL_W  = COL_W_DEF,
  parameter int MAX_CL = MAX_CL_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [LEN_W-1:0] burst_len_i,
  input  logic             burst_type_i,
  input  logic             cas_lat_i,
  input  logic             term_i,
  output logic [COL_W-1:0] col_o,
  output logic             col_valid_o,
  output logic             data_valid_o,
  output logic             burst_done_o
);
  localparam int TAP_W = (MAX_CL > 1) ? $clog2(MAX_CL) : 1;

  logic             vld_w, last_w;
  logic [TAP_W-1:0] tap_q;

  // tap = latency - 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tap_q <= TAP_W'(1);
    else if (start_i) tap_q <= cas_lat_i ? TAP_W'(2) : TAP_W'(1);
  end

  sdr_col_gen #(.COL_W(COL_W)) u_col_gen (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .term_i      (term_i),
    .start_col_i (start_col_i),
    .len_code_i  (burst_len_i),
    .order_i     (burst_order_e'(burst_type_i)),
    .col_o       (col_o),
    .col_vld_o   (vld_w),
    .last_o      (last_w)
  );

  sdr_lat_pipe #(.MAX_CL(MAX_CL)) u_lat_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (vld_w),
    .last_i (last_w),
    .tap_i  (tap_q),
    .dv_o   (data_valid_o),
    .done_o (burst_done_o)
  );

  assign col_valid_o = vld_w;

  p_reset_quiet_r9: assert property (@(posedge clk_i)
    !rst_ni |-> (!col_valid_o && !data_valid_o && !burst_done_o));
endmodule

// File: tb/tb_sdr_burst_seq.sv
module tb_sdr_burst_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [8:0] start_col_i = '0;
  logic [2:0] burst_len_i = '0;
  logic       burst_type_i = 1'b0;
  logic       cas_lat_i = 1'b0;
  logic       term_i = 1'b0;
  logic [8:0] col_o;
  logic       col_valid_o, data_valid_o, burst_done_o;

  always #2 clk_i = ~clk_i;

  sdr_burst_seq dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .start_col_i(start_col_i),
    .burst_len_i(burst_len_i), .burst_type_i(burst_type_i), .cas_lat_i(cas_lat_i),
    .term_i(term_i), .col_o(col_o), .col_valid_o(col_valid_o),
    .data_valid_o(data_valid_o), .burst_done_o(burst_done_o)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  // reference state
  logic [8:0] m_base, m_col;
  logic [2:0] m_code;
  logic       m_type, m_busy;
  int         m_k, m_cl;
  logic [3:0] h_cv, h_last;

  function automatic logic [8:0] f_addr(logic [8:0] s, logic [2:0] code, logic ty, int k);
    int len;
    if (code[2]) return 9'(int'(s) + k);
    len = 1 << code[1:0];
    if (ty) return s ^ 9'(k % len);
    return (s & ~9'(len - 1)) | (9'(int'(s) + k) & 9'(len - 1));
  endfunction

  task automatic model_reset();
    m_base = '0; m_col = '0; m_code = '0; m_type = 1'b0; m_busy = 1'b0;
    m_k = 0; m_cl = 2; h_cv = '0; h_last = '0;
  endtask

  task automatic model_step();
    logic cv, lst;
    cv = 1'b0; lst = 1'b0;
    if (start_i) begin
      m_base = start_col_i; m_code = burst_len_i; m_type = burst_type_i;
      m_cl = cas_lat_i ? 3 : 2; m_k = 0; m_busy = 1'b1;
    end else if (term_i) m_busy = 1'b0;
    if (m_busy) begin
      cv = 1'b1;
      m_col = f_addr(m_base, m_code, m_type, m_k);
      if (!m_code[2] && m_k == (1 << m_code[1:0]) - 1) begin lst = 1'b1; m_busy = 1'b0; end
      m_k++;
    end
    h_cv = {h_cv[2:0], cv};
    h_last = {h_last[2:0], lst};
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "col_valid_o", col_valid_o, h_cv[0]);
    if (h_cv[0]) chk(tag, "col_o", col_o, m_col);
    chk(tag, "data_valid_o", data_valid_o, h_cv[m_cl]);
    chk(tag, "burst_done_o", burst_done_o, h_last[m_cl]);
  endtask

  // inputs are set at a negedge; apply one edge and compare
  task automatic tick(string tag);
    model_step();
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0; term_i = 1'b0;
    compare(tag);
  endtask

  task automatic go(logic [8:0] c, logic [2:0] l, logic ty, logic cl, string tag);
    start_i = 1'b1; start_col_i = c; burst_len_i = l; burst_type_i = ty; cas_lat_i = cl;
    tick(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  task automatic stop(string tag);
    term_i = 1'b1;
    tick(tag);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4321));
    model_reset();
    #5;
    // R9: outputs quiet while in reset
    chk("R9", "col_valid_o", col_valid_o, 0);
    chk("R9", "data_valid_o", data_valid_o, 0);
    chk("R9", "burst_done_o", burst_done_o, 0);
    chk("R9", "col_o", col_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle(2, "R9");

    // R1: every fixed length, R5 both latencies
    for (int l = 0; l < 4; l++) begin go(9'd5, 3'(l), 1'b0, 1'b0, "R1"); idle(12, "R1"); end
    for (int l = 0; l < 4; l++) begin go(9'd37, 3'(l), 1'b1, 1'b1, "R5"); idle(12, "R5"); end
    // R2 / R3: unaligned start, wrap within block
    go(9'd13, 3'd3, 1'b0, 1'b0, "R2"); idle(12, "R2");
    go(9'd13, 3'd3, 1'b1, 1'b0, "R3"); idle(12, "R3");
    go(9'd266, 3'd2, 1'b1, 1'b1, "R3"); idle(8, "R3");
    // R4: full page wraps 511 -> 0, type ignored
    go(9'd508, 3'd7, 1'b1, 1'b0, "R4"); idle(600, "R4"); stop("R4"); idle(6, "R4");
    go(9'd0, 3'd4, 1'b0, 1'b1, "R4"); idle(20, "R4"); stop("R4"); idle(6, "R4");
    // R6: done with last word, latency 3
    go(9'd100, 3'd2, 1'b0, 1'b1, "R6"); idle(10, "R6");
    go(9'd200, 3'd0, 1'b0, 1'b0, "R6"); go(9'd201, 3'd0, 1'b1, 1'b0, "R6"); idle(6, "R6");
    // R7: terminate mid-burst, then start and terminate together
    go(9'd64, 3'd3, 1'b0, 1'b1, "R7"); idle(2, "R7"); stop("R7"); idle(6, "R7");
    start_i = 1'b1; term_i = 1'b1; start_col_i = 9'd77; burst_len_i = 3'd2;
    burst_type_i = 1'b0; cas_lat_i = 1'b1; tick("R7"); idle(8, "R7");
    // R8: restart mid-burst
    go(9'd300, 3'd3, 1'b0, 1'b0, "R8"); idle(3, "R8");
    go(9'd45, 3'd2, 1'b1, 1'b0, "R8"); idle(10, "R8");
    // R10: mode inputs wiggle during a burst
    go(9'd150, 3'd3, 1'b1, 1'b0, "R10");
    for (int i = 0; i < 10; i++) begin
      start_col_i = 9'($urandom); burst_len_i = 3'($urandom);
      burst_type_i = 1'($urandom); cas_lat_i = 1'($urandom);
      tick("R10");
    end

    // constrained random blocks, latency fixed per block
    for (int b = 0; b < 8; b++) begin
      logic cl_b;
      cl_b = 1'(b);
      for (int i = 0; i < 1500; i++) begin
        start_i = ($urandom_range(11) == 0);
        term_i = ($urandom_range(29) == 0);
        start_col_i = 9'($urandom); burst_len_i = 3'($urandom);
        burst_type_i = 1'($urandom);
        cas_lat_i = start_i ? cl_b : 1'($urandom);
        tick("R10");
      end
      stop("R7"); idle(5, "R7");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule